// File: doc/BRIEF.md
# Free-Running System Counter with Compare Interrupt

This block keeps a 64-bit count that only moves upward and provides one compare channel that drives a level interrupt. Software reaches it through a plain 32-bit strobe bus. The count sits behind two 32-bit read words. The compare target is written as a low word and a 20-bit high word. A control word holds the enable, the interrupt mask and a read-only status flag. A static configuration pin selects the count rate: one step per clock, or one step per three clocks.

To arm the channel, software clears the enable, reads the count, and writes a target ahead of it. It then sets the enable again. When the count reaches the target, the status flag sets and stays set. To acknowledge the interrupt, software clears the enable bit, which also clears the status. No separate status write is needed.

Top module: `free_counter_cmp`

## Requirements
- R1: After a synchronous reset, every readable word reads zero and `irq` is low.
- R2: The count's low word reads at address 0x8 and its high word at 0xC. With `div_bypass` = 1 the count advances by one on every clock.
- R3: With `div_bypass` = 0 the count advances exactly once in every three clocks.
- R4: The compare low word is at 0x10020, the compare high word at 0x10024 and the control word at 0x1002C. In the control word, bit 0 is the enable, bit 1 is the mask and bit 2 is the status (read-only). Bits 31:3 read zero.
- R5: Only bits 19:0 of the compare high word are stored and compared. Bits 31:20 are ignored on write and read as zero.
- R6: While the enable is 1 and the count is at or above the 52-bit compare value, the status sets at that clock. It stays set while the enable stays 1, and `irq` is high from the next sample.
- R7: A write that clears the enable clears the status and drops `irq` at that same clock edge.
- R8: `irq` is a registered level equal to status AND enable AND NOT mask. Setting the mask hides `irq` but leaves the status unchanged.
- R9: If the compare value is already in the past, the status sets at the clock edge of the write that sets the enable.
- R10: Reads do not latch or freeze the count. Two reads of the low word on consecutive clocks differ by one in undivided mode. Reading high, then low, then high again returns the same high word while no carry occurs.
- R11: While the enable is 0, the status stays 0 even when the count is past the compare value.
- R12: A read returns its data on `rdata` with `rd_valid` high one clock after `rd_en` is sampled. The data is the count as it stood at that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div_bypass | input | 1 | Static: 1 = count every clock, 0 = count every third clock |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 17 | Byte address of the word accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | High for one clock when `rdata` holds a read result |
| irq | output | 1 | Level interrupt from the compare channel |

## Verification
The count is sampled over a long gap and over short gaps in both rate modes. The long gap shows whether the rate is right. The short gaps show whether a read disturbs the count or whether the divided mode ever steps twice within three clocks.

The compare channel is tested with three kinds of target:
- A target just ahead of the count. This pins the exact clock at which `irq` rises: the next read must return the target plus one.
- A target already passed. This separates "set on the enable write" from "set one clock late".
- A target far in the future. This shows that the 20-bit high word really takes part in the comparison.

The mask and the enable are then toggled one at a time. This separates hiding the interrupt from acknowledging it.

// File: rtl/cntcmp_pkg.sv
package cntcmp_pkg;
  localparam int unsigned CMP_FRAME  = 32'h1_0000;
  localparam int unsigned OFF_CNT_LO = 32'h8;
  localparam int unsigned OFF_CNT_HI = 32'hC;
  localparam int unsigned OFF_CMP_LO = CMP_FRAME + 32'h20;
  localparam int unsigned OFF_CMP_HI = CMP_FRAME + 32'h24;
  localparam int unsigned OFF_CTRL   = CMP_FRAME + 32'h2C;

  // control word layout: en at bit 0, mask at bit 1, status at bit 2
  typedef struct packed {
    logic stat;
    logic mask;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/cc_prescale.sv
module cc_prescale #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bypass,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  generate
    if (DIV > 1) begin : g_div
      logic [PW-1:0] phase;
      always_ff @(posedge clk) begin
        if (rst || bypass)      phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
      end
      assign tick = bypass | (phase == LAST);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/cc_counter.sv
module cc_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;   // wraps silently to zero
  end
endmodule

// File: rtl/cc_compare.sv
module cc_compare
  import cntcmp_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int DATA_W   = 32,
  parameter int CMP_HI_W = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we_lo,
  input  logic                we_hi,
  input  logic                we_ctrl,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [CNT_W-1:0]    cnt,
  output logic [DATA_W-1:0]   cmp_lo,
  output logic [CMP_HI_W-1:0] cmp_hi,
  output ctrl_t               ctrl,
  output logic                irq
);
  localparam int CMP_W = DATA_W + CMP_HI_W;

  logic             en_d, mk_d, st_d, hit;
  logic [CMP_W-1:0] target;

  always_comb begin
    target = {cmp_hi, cmp_lo};
    hit    = (cnt >= CNT_W'(target));
    en_d   = we_ctrl ? wdata[0] : ctrl.en;
    mk_d   = we_ctrl ? wdata[1] : ctrl.mask;
    st_d   = en_d & (ctrl.stat | hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_lo <= '0;
      cmp_hi <= '0;
      ctrl   <= '0;
      irq    <= 1'b0;
    end else begin
      if (we_lo) cmp_lo <= wdata;
      if (we_hi) cmp_hi <= wdata[CMP_HI_W-1:0];
      ctrl.en   <= en_d;
      ctrl.mask <= mk_d;
      ctrl.stat <= st_d;
      irq       <= st_d & en_d & ~mk_d;
    end
  end
endmodule

// File: rtl/cc_regif.sv
module cc_regif
  import cntcmp_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 64,
  parameter int CMP_HI_W = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [DATA_W-1:0]   cmp_lo,
  input  logic [CMP_HI_W-1:0] cmp_hi,
  input  ctrl_t               ctrl,
  output logic                we_lo,
  output logic                we_hi,
  output logic                we_ctrl,
  output logic [DATA_W-1:0]   rdata,
  output logic                rd_valid
);
  localparam logic [ADDR_W-1:0] A_CLO = ADDR_W'(OFF_CNT_LO);
  localparam logic [ADDR_W-1:0] A_CHI = ADDR_W'(OFF_CNT_HI);
  localparam logic [ADDR_W-1:0] A_MLO = ADDR_W'(OFF_CMP_LO);
  localparam logic [ADDR_W-1:0] A_MHI = ADDR_W'(OFF_CMP_HI);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFF_CTRL);

  logic [DATA_W-1:0] rmux;

  assign we_lo   = wr_en && (addr == A_MLO);
  assign we_hi   = wr_en && (addr == A_MHI);
  assign we_ctrl = wr_en && (addr == A_CTL);

  always_comb begin
    unique case (addr)
      A_CLO:   rmux = cnt[DATA_W-1:0];
      A_CHI:   rmux = cnt[2*DATA_W-1:DATA_W];
      A_MLO:   rmux = cmp_lo;
      A_MHI:   rmux = DATA_W'(cmp_hi);
      A_CTL:   rmux = DATA_W'(ctrl);
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rmux;
    end
  end
endmodule

// File: rtl/free_counter_cmp.sv
module free_counter_cmp
  import cntcmp_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 32,
  parameter int CMP_HI_W = 20,
  parameter int DIV      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              div_bypass,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic                tick;
  logic [CNT_W-1:0]    cnt;
  logic [DATA_W-1:0]   cmp_lo;
  logic [CMP_HI_W-1:0] cmp_hi;
  ctrl_t               ctrl;
  logic                we_lo, we_hi, we_ctrl;

  cc_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .bypass(div_bypass), .tick(tick)
  );

  cc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt)
  );

  cc_compare #(.CNT_W(CNT_W), .DATA_W(DATA_W), .CMP_HI_W(CMP_HI_W)) u_cmp (
    .clk(clk), .rst(rst), .we_lo(we_lo), .we_hi(we_hi), .we_ctrl(we_ctrl),
    .wdata(wdata), .cnt(cnt), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
    .ctrl(ctrl), .irq(irq)
  );

  cc_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
             .CMP_HI_W(CMP_HI_W)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .cnt(cnt), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .ctrl(ctrl),
    .we_lo(we_lo), .we_hi(we_hi), .we_ctrl(we_ctrl),
    .rdata(rdata), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/cc_checker.sv
module cc_checker #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             bypass,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             en,
  input logic             mask,
  input logic             stat,
  input logic             irq,
  input logic             rd_en,
  input logic             rd_valid
);
  a_r2_bypass_ticks: assert property (@(posedge clk) disable iff (rst)
    bypass |-> tick);

  a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (!bypass && tick) |=> !tick);

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> cnt == $past(cnt) + CNT_W'($past(tick)));

  a_r7_clear_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(en) |-> (!stat && !irq));

  a_r11_idle_clear: assert property (@(posedge clk) disable iff (rst)
    !en |-> !stat);

  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (stat && en) |=> (stat || !en));

  a_r8_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == (stat && en && !mask));

  a_r12_read_lat: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

bind free_counter_cmp cc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bypass(div_bypass), .tick(tick), .cnt(cnt),
  .en(ctrl.en), .mask(ctrl.mask), .stat(ctrl.stat), .irq(irq),
  .rd_en(rd_en), .rd_valid(rd_valid)
);

// File: tb/free_counter_cmp_tb.sv
`timescale 1ns/1ps
module free_counter_cmp_tb;
  localparam logic [16:0] A_CLO = 17'h00008;
  localparam logic [16:0] A_CHI = 17'h0000C;
  localparam logic [16:0] A_MLO = 17'h10020;
  localparam logic [16:0] A_MHI = 17'h10024;
  localparam logic [16:0] A_CTL = 17'h1002C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        div_bypass = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [16:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  free_counter_cmp u_dut (
    .clk(clk), .rst(rst), .div_bypass(div_bypass), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rd_valid(rd_valid), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [16:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [16:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
    chk("R12 rd_valid", {31'b0, rd_valid}, 32'd1);
  endtask

  task automatic do_reset(input logic byp);
    div_bypass = byp;
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset(1'b1);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    bus_rd(A_CHI, v); chk("R1 cnt hi", v, 32'd0);
    bus_rd(A_MLO, v); chk("R1 cmp lo", v, 32'd0);
    bus_rd(A_MHI, v); chk("R1 cmp hi", v, 32'd0);
    bus_rd(A_CTL, v); chk("R1 ctrl", v, 32'd0);
  endtask

  task automatic t_rate_bypass();
    logic [31:0] a, b, h1, h2;
    bus_rd(A_CLO, a); idle(29); bus_rd(A_CLO, b);
    chk("R2 30-clock delta", b - a, 32'd30);
    bus_rd(A_CLO, a); bus_rd(A_CLO, b);
    chk("R10 back-to-back delta", b - a, 32'd1);
    bus_rd(A_CHI, h1); bus_rd(A_CLO, a); bus_rd(A_CHI, h2);
    chk("R10 hi-lo-hi consistent", h2, h1);
  endtask

  task automatic t_rate_div();
    logic [31:0] a, b;
    do_reset(1'b0);
    bus_rd(A_CLO, a); idle(29); bus_rd(A_CLO, b);
    chk("R3 30-clock delta", b - a, 32'd10);
    bus_rd(A_CLO, a); idle(2); bus_rd(A_CLO, b);
    chk("R3 3-clock delta", b - a, 32'd1);
    do_reset(1'b1);
  endtask

  task automatic t_hi_width();
    logic [31:0] v;
    bus_wr(A_MHI, 32'hFFFF_FFFF);
    bus_rd(A_MHI, v); chk("R5 hi readback", v, 32'h000F_FFFF);
    bus_wr(A_CTL, 32'd1); idle(3);
    chk("R5 far target no irq", {31'b0, irq}, 32'd0);
    bus_wr(A_CTL, 32'd0);
    bus_wr(A_MHI, 32'hFFF0_0000);
    bus_rd(A_MHI, v); chk("R5 upper ignored", v, 32'd0);
    bus_wr(A_MLO, 32'd0);
  endtask

  task automatic t_past_and_mask();
    logic [31:0] v;
    // target 0 is in the past; enable stays off
    idle(4);
    chk("R11 idle irq", {31'b0, irq}, 32'd0);
    bus_rd(A_CTL, v); chk("R11 status idle", v, 32'd0);
    bus_wr(A_CTL, 32'd1);
    chk("R9 irq after enable write", {31'b0, irq}, 32'd1);
    bus_rd(A_CTL, v); chk("R4 ctrl en+stat", v, 32'd5);
    bus_wr(A_CTL, 32'd3);
    chk("R8 masked irq", {31'b0, irq}, 32'd0);
    bus_rd(A_CTL, v); chk("R8 stat kept under mask", v, 32'd7);
    bus_wr(A_CTL, 32'd1);
    chk("R8 unmask irq", {31'b0, irq}, 32'd1);
    bus_wr(A_CTL, 32'd0);
    chk("R7 ack irq", {31'b0, irq}, 32'd0);
    bus_rd(A_CTL, v); chk("R7 ctrl cleared", v, 32'd0);
  endtask

  task automatic t_future_hit();
    logic [31:0] v, tgt;
    int guard;
    bus_rd(A_CLO, v);
    tgt = v + 32'd60;
    bus_wr(A_MHI, 32'd0);
    bus_wr(A_MLO, tgt);
    bus_rd(A_MLO, v); chk("R4 cmp lo readback", v, tgt);
    bus_wr(A_CTL, 32'd1);
    chk("R6 no early irq", {31'b0, irq}, 32'd0);
    guard = 0;
    while (!irq && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    bus_rd(A_CLO, v);
    chk("R6 irq rises when count hits target", v, tgt + 32'd1);
    idle(5);
    chk("R6 irq sticky", {31'b0, irq}, 32'd1);
    bus_wr(A_CTL, 32'd0);
    chk("R7 ack after hit", {31'b0, irq}, 32'd0);
  endtask

  initial begin
    #(200_000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rate_bypass();
    t_hi_width();
    t_past_and_mask();
    t_future_hit();
    t_rate_div();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule